// File: doc/BRIEF.md
# I2C Master START/STOP Condition Generator with SDA Edge Delay

This block is the bit-timing core of an I2C-style bus master. A reload value sets the SCL half period, and the block runs SCL from it. It produces START, repeated START and STOP conditions. Each condition has a hold window or a setup window of one half period. Both bus lines are open-drain, so the block only ever asks for a line to be pulled low. It never drives a line high.

SDA changes can be held back by a 3-bit programmable number of base-clock cycles. Because of this delay, the real START hold time is shorter than half a period and the real STOP setup time is longer, each by the delay. The block reads the SCL line back through a two-stage synchronizer, so a slave can stretch the clock. The high half of each bit is timed from the moment the line is seen high. The block absorbs the synchronizer latency, and for that reason reload values below 3 are raised to 3.

START and STOP requests are single-cycle strobes. They are latched and then acted on at the next bit boundary, or at once when the bus is idle. Shifting data bytes, acknowledge, arbitration and slave operation are not part of this block.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset, scl_drive_low, sda_drive_low, busy and done are all 0.
- R2: A start_req while idle raises busy and pulls SDA low while SCL stays released. SCL is then pulled low n+1 cycles after the SDA request, where n is the effective reload value.
- R3: While busy, each SCL low phase lasts n+1 cycles. Each high phase lasts n+1 cycles, measured from the time the SCL line is released, which gives an SCL period of 2(n+1) base-clock cycles.
- R4: If a slave holds SCL low after the block releases it, the high phase lasts n+1 cycles counted from the time the line actually goes high. SCL is not pulled low again while it is being stretched.
- R5: A delay setting k (0 to 7) delays every change of sda_drive_low by exactly k cycles, so the START hold time seen on the pins is n+1-k cycles. A setting of 0 adds no delay.
- R6: The STOP setup time, from the final SCL rise to the SDA release, is n+1+k cycles.
- R7: A stop_req made while busy takes effect at the end of the current bit. One more bit is clocked with SDA held low, and SDA is then released. done is high for exactly one cycle, and it rises in the same cycle as the undelayed SDA release. busy is 0 from the following cycle on.
- R8: A reload value of 0, 1 or 2 behaves as 3, so no SCL low phase is shorter than 4 cycles.
- R9: A start_req made while busy produces a repeated START at the end of the current bit. During the next low phase SDA is released. SCL is then released, and after n+1 cycles SDA is pulled low with SCL high. SCL falls n+1 cycles after that.
- R10: A stop_req made while idle is ignored. busy stays 0 and neither line is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| reload | input | 8 | Half-period reload value n (values below 3 act as 3) |
| sda_dly | input | 3 | SDA edge delay in base-clock cycles |
| start_req | input | 1 | One-cycle START / repeated START request |
| stop_req | input | 1 | One-cycle STOP request |
| scl_in | input | 1 | SCL line level as read back from the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| busy | output | 1 | High from START acceptance until one cycle after the STOP completes |
| done | output | 1 | One-cycle pulse when the STOP releases SDA |

## Verification
The bench measures hold, low, high and setup windows for several pairs of reload value and delay, including a reload of 1 that must be clamped and a delay of 7. A design that applied the delay to SCL instead of SDA, or that did not absorb the synchronizer latency, would produce windows that are off by k or by 3 cycles. A stretched clock must lengthen the high phase by the stretch exactly: a design that started timing at release would fall early and cut the stretch short. A repeated START must release SDA in the low phase and pull it low again only after a full high window. A stop_req while idle must leave the bus silent, and a design that did otherwise would start a spurious transaction.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    // Smallest legal reload: SCL read-back needs this many cycles to be seen
    localparam int MIN_RELOAD  = 3;
    // Synchronizer depth on the SCL read-back path
    localparam int SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        PH_IDLE,   // bus free, both lines released
        PH_HOLD,   // SDA low with SCL high (START hold)
        PH_LOW,    // SCL pulled low
        PH_RISE,   // SCL released, waiting to see it high
        PH_HIGH,   // SCL high, timing the high half
        PH_FIN     // STOP finished, done pulse
    } phase_e;

    typedef enum logic [1:0] {
        BIT_PLAIN,    // ordinary bit, SDA held low
        BIT_STOP,     // bit that ends in a STOP
        BIT_RESTART   // bit that ends in a repeated START
    } bit_kind_e;

endpackage

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_sync
);
    logic [STAGES-1:0] ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) ff_q <= '1;
                else     ff_q <= line_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) ff_q <= '1;
                else     ff_q <= {ff_q[STAGES-2:0], line_in};
            end
        end
    endgenerate

    assign line_sync = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_sda_delay.sv
module i2c_sda_delay #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DLY_W-1:0] dly,
    input  logic             d_in,
    output logic             d_out
);
    localparam int DEPTH = (1 << DLY_W) - 1;

    logic [DEPTH-1:0] tap_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) tap_q <= '0;
                else     tap_q <= d_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) tap_q <= '0;
                else     tap_q <= {tap_q[DEPTH-2:0], d_in};
            end
        end
    endgenerate

    always_comb begin
        if (dly == '0) d_out = d_in;
        else           d_out = tap_q[int'(dly) - 1];
    end
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] reload,
    input  logic [DLY_W-1:0] sda_dly,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    output logic             busy,
    output logic             done
);
    localparam logic [CNT_W-1:0] MIN_N    = CNT_W'(MIN_RELOAD);
    // cycles spent seeing the line high before the high timer starts
    localparam logic [CNT_W-1:0] RISE_LAT = CNT_W'(SYNC_STAGES + 1);

    phase_e           phase_q;
    bit_kind_e        kind_q;
    logic             sda_req_q;
    logic             start_pend_q;
    logic             stop_pend_q;
    logic             scl_seen;
    logic             half_over;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] n_eff;

    assign n_eff = (reload < MIN_N) ? MIN_N : reload;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_in  (scl_in),
        .line_sync(scl_seen)
    );

    i2c_half_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (half_over)
    );

    i2c_sda_delay #(.DLY_W(DLY_W)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .dly  (sda_dly),
        .d_in (sda_req_q),
        .d_out(sda_drive_low)
    );

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = n_eff;
        unique case (phase_q)
            PH_IDLE: tmr_load = start_pend_q;
            PH_HOLD: tmr_load = half_over;
            PH_RISE: begin
                tmr_load = scl_seen;
                tmr_val  = n_eff - RISE_LAT;
            end
            PH_HIGH: tmr_load = half_over && (kind_q != BIT_STOP);
            default: tmr_load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_IDLE;
            kind_q       <= BIT_PLAIN;
            sda_req_q    <= 1'b0;
            start_pend_q <= 1'b0;
            stop_pend_q  <= 1'b0;
        end else begin
            start_pend_q <= start_pend_q | start_req;
            stop_pend_q  <= stop_pend_q | stop_req;
            unique case (phase_q)
                PH_IDLE: begin
                    stop_pend_q <= 1'b0;
                    if (start_pend_q) begin
                        phase_q      <= PH_HOLD;
                        kind_q       <= BIT_PLAIN;
                        sda_req_q    <= 1'b1;
                        start_pend_q <= start_req;
                    end
                end
                PH_HOLD: if (half_over) phase_q <= PH_LOW;
                PH_LOW:  if (half_over) phase_q <= PH_RISE;
                PH_RISE: if (scl_seen)  phase_q <= PH_HIGH;
                PH_HIGH: begin
                    if (half_over) begin
                        unique case (kind_q)
                            BIT_STOP: begin
                                sda_req_q <= 1'b0;
                                phase_q   <= PH_FIN;
                            end
                            BIT_RESTART: begin
                                sda_req_q <= 1'b1;
                                kind_q    <= BIT_PLAIN;
                                phase_q   <= PH_HOLD;
                            end
                            default: begin
                                phase_q <= PH_LOW;
                                if (stop_pend_q) begin
                                    kind_q       <= BIT_STOP;
                                    stop_pend_q  <= stop_req;
                                    start_pend_q <= start_req;
                                end else if (start_pend_q) begin
                                    kind_q       <= BIT_RESTART;
                                    sda_req_q    <= 1'b0;
                                    start_pend_q <= start_req;
                                end
                            end
                        endcase
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign scl_drive_low = (phase_q == PH_LOW);
    assign busy          = (phase_q != PH_IDLE);
    assign done          = (phase_q == PH_FIN);
endmodule

// File: rtl/i2c_cond_gen_chk.sv
module i2c_cond_gen_chk (
    input logic clk,
    input logic rst,
    input logic scl_drive_low,
    input logic busy,
    input logic done
);
    logic [15:0] low_run_q;

    always_ff @(posedge clk) begin
        if (rst)                low_run_q <= '0;
        else if (scl_drive_low) low_run_q <= low_run_q + 1'b1;
        else                    low_run_q <= '0;
    end

    // R7
    done_width_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R10
    idle_scl_free_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !scl_drive_low);

    // R2
    start_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !scl_drive_low);

    // R8
    min_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_drive_low) |-> (low_run_q >= 16'd4));
endmodule

bind i2c_cond_gen i2c_cond_gen_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_drive_low(scl_drive_low),
    .busy         (busy),
    .done         (done)
);

// File: tb/i2c_cond_gen_tb.sv
`timescale 1ns/1ps
module i2c_cond_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reload = 8'd9;
    logic [2:0] sda_dly = 3'd0;
    logic       start_req = 1'b0;
    logic       stop_req = 1'b0;
    logic       stretch = 1'b0;
    logic       scl_in;
    logic       scl_drive_low, sda_drive_low, busy, done;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    assign scl_in = ~(scl_drive_low | stretch);

    i2c_cond_gen u_dut (
        .clk(clk), .rst(rst), .reload(reload), .sda_dly(sda_dly),
        .start_req(start_req), .stop_req(stop_req), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [7:0]  rl;
        logic [2:0]  k;
        logic [15:0] hold;
        logic [15:0] half;
        logic [15:0] setup;
    } row_t;

    // expected: half = max(rl,3)+1, hold = half-k, setup = half+k
    localparam int NROWS = 7;
    localparam row_t ROWS [NROWS] = '{
        '{8'd3,  3'd0, 16'd4,  16'd4,  16'd4},
        '{8'd9,  3'd0, 16'd10, 16'd10, 16'd10},
        '{8'd9,  3'd5, 16'd5,  16'd10, 16'd15},
        '{8'd1,  3'd0, 16'd4,  16'd4,  16'd4},
        '{8'd20, 3'd7, 16'd14, 16'd21, 16'd28},
        '{8'd6,  3'd2, 16'd5,  16'd7,  16'd9},
        '{8'd3,  3'd3, 16'd1,  16'd4,  16'd7}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic get_sig(input int sel);
        case (sel)
            0: return scl_drive_low;
            1: return sda_drive_low;
            2: return busy;
            default: return done;
        endcase
    endfunction

    task automatic wait_for(input int sel, input logic val, input int first, output int n);
        n = first;
        while (get_sig(sel) !== val && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 3000) check(1'b0, "wait timeout", n, 0);
    endtask

    task automatic pulse_start();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    initial begin
        #(150000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        // R1 reset state
        check({scl_drive_low, sda_drive_low, busy, done} == 4'b0000, "R1 reset outputs",
              int'({scl_drive_low, sda_drive_low, busy, done}), 0);
        rst = 1'b0;
        @(negedge clk);

        // table of timing windows: R2 R3 R5 R6 R7 R8
        for (int i = 0; i < NROWS; i++) begin
            reload  = ROWS[i].rl;
            sda_dly = ROWS[i].k;
            @(negedge clk);
            pulse_start();
            wait_for(1, 1'b1, 0, n);
            check(scl_drive_low == 1'b0 && busy, "R2 SDA low with SCL released", int'(scl_drive_low), 0);
            wait_for(0, 1'b1, 0, n);
            check(n == int'(ROWS[i].hold), "R2/R5 start hold", n, int'(ROWS[i].hold));
            pulse_stop();
            wait_for(0, 1'b0, 1, n);
            check(n == int'(ROWS[i].half), "R3/R8 low phase", n, int'(ROWS[i].half));
            wait_for(0, 1'b1, 0, n);
            check(n == int'(ROWS[i].half), "R3 high phase", n, int'(ROWS[i].half));
            wait_for(0, 1'b0, 0, n);
            check(sda_drive_low == 1'b1, "R7 SDA held low in stop bit", int'(sda_drive_low), 1);
            wait_for(1, 1'b0, 0, n);
            check(n == int'(ROWS[i].setup), "R6 stop setup", n, int'(ROWS[i].setup));
            if (ROWS[i].k == 3'd0) begin
                check(done && busy, "R7 done with SDA release", int'({done, busy}), 3);
                @(negedge clk);
                check(!done && !busy, "R7 done one cycle, busy clear", int'({done, busy}), 0);
            end
            wait_for(2, 1'b0, 0, n);
            repeat (10) @(negedge clk);
        end

        // R10: stop while idle ignored
        reload = 8'd9; sda_dly = 3'd0;
        pulse_stop();
        begin
            bit quiet = 1'b1;
            for (int c = 0; c < 30; c++) begin
                if (busy || scl_drive_low || sda_drive_low) quiet = 1'b0;
                @(negedge clk);
            end
            check(quiet, "R10 idle stop ignored", int'(quiet), 1);
        end

        // R4: clock stretching
        pulse_start();
        wait_for(0, 1'b1, 0, n);
        stretch = 1'b1;
        wait_for(0, 1'b0, 0, n);
        begin
            bit held = 1'b1;
            for (int c = 0; c < 15; c++) begin
                @(negedge clk);
                if (scl_drive_low) held = 1'b0;
            end
            check(held, "R4 no drive while stretched", int'(held), 1);
        end
        stretch = 1'b0;
        wait_for(0, 1'b1, 0, n);
        check(n == 10, "R4 high after stretch", n, 10);
        pulse_stop();
        wait_for(2, 1'b0, 0, n);
        repeat (10) @(negedge clk);

        // R9: repeated START
        reload = 8'd5;
        @(negedge clk);
        pulse_start();
        wait_for(0, 1'b1, 0, n);
        pulse_start();
        wait_for(0, 1'b0, 0, n);
        wait_for(0, 1'b1, 0, n);
        check(sda_drive_low == 1'b0, "R9 SDA released in low phase", int'(sda_drive_low), 0);
        wait_for(0, 1'b0, 0, n);
        wait_for(1, 1'b1, 0, n);
        check(n == 6 && !scl_drive_low, "R9 restart setup", n, 6);
        wait_for(0, 1'b1, 0, n);
        check(n == 6, "R9 restart hold", n, 6);
        check(busy == 1'b1, "R9 busy through restart", int'(busy), 1);
        pulse_stop();
        wait_for(2, 1'b0, 0, n);
        check(sda_drive_low == 1'b0 && scl_drive_low == 1'b0, "R7 lines free after stop",
              int'({scl_drive_low, sda_drive_low}), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule